// File: doc/BRIEF.md
# Paddle Game Flow and Difficulty Controller

This block sequences a single-player paddle-and-ball game. It waits in an idle state until the player presses start. It then runs the game until the ball logic reports a miss, and it stays in a game-over state until the reset button is pressed. The start and reset buttons are synchronised to the clock and edge-detected, so one press takes effect once no matter how long it is held.

While a game runs, a nested level counter counts the one-second ticks. Every `SECS_PER_LEVEL` ticks it raises the difficulty level by one, up to the last of `NUM_LEVELS` levels, and then holds there. The level is output as a speed-select code. The code also picks one of several step periods, and a step generator emits a one-cycle pulse at that period to move the ball. A higher code gives a shorter period and so a faster ball.

Top module: `pong_flow_ctrl`

## Requirements
- R1: After the asynchronous reset rst_ni the block is idle: playing_o=0, over_o=0, speed_sel_o=0 and step_o=0.
- R2: In idle, a start press puts the block in play (playing_o=1, over_o=0) with speed_sel_o=0.
- R3: In play, miss_i high for one cycle ends the game: playing_o=0 and over_o=1 from the next cycle on. playing_o and over_o are never both high.
- R4: In play, speed_sel_o rises by exactly 1 after every SECS_PER_LEVEL one-second ticks counted since the start.
- R5: speed_sel_o saturates at NUM_LEVELS-1 (code 4 by default) and stays there while play continues.
- R6: In play, step_o pulses high for one cycle every BASE_PERIOD - speed_sel_o*PERIOD_DEC cycles. step_o stays low in idle and in game-over.
- R7: In game-over, start presses and ticks are ignored: the block stays in game-over and speed_sel_o keeps its last value.
- R8: A reset-button press returns the block to idle from any state, with speed_sel_o=0 and over_o=0.
- R9: A button held high acts only once, on its rising edge. While the reset button is still held after it has acted, a start press begins a game and that game keeps running.
- R10: Each new start clears the partial tick count of the previous game, so the first level rise needs a full SECS_PER_LEVEL ticks.
- R11: Ticks outside play do not change speed_sel_o. A tick in the same cycle as a miss is ignored, so the level does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| reset_btn_i | input | 1 | Raw reset pushbutton, asynchronous to clk_i |
| start_btn_i | input | 1 | Raw start pushbutton, asynchronous to clk_i |
| miss_i | input | 1 | One-cycle pulse from ball logic: ball missed the paddle |
| sec_tick_i | input | 1 | One-cycle pulse once per second |
| playing_o | output | 1 | Game in progress |
| over_o | output | 1 | Game ended, waiting for reset button |
| speed_sel_o | output | $clog2(NUM_LEVELS) | Difficulty level code, 0 to NUM_LEVELS-1 |
| step_o | output | 1 | One-cycle ball step pulse at the selected rate |

## Verification
The bench builds the block with SECS_PER_LEVEL=3, BASE_PERIOD=12 and PERIOD_DEC=2, which gives step periods 12, 10, 8, 6 and 4 cycles. With these values, all five levels, the saturation at code 4 and the period of every level can be reached within a few hundred cycles. Between directed cases for buttons and misses, seeded random tick gaps drive level progression. A reference model counts ticks and predicts the code after each one.

// File: rtl/pong_ctrl_pkg.sv
package pong_ctrl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PLAY = 2'd1,
    ST_OVER = 2'd2
  } game_st_e;
endpackage

// File: rtl/pong_btn_edge.sv
module pong_btn_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic btn_i,
  output logic press_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], btn_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign press_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/pong_level_ctr.sv
module pong_level_ctr #(
  parameter int unsigned NUM_LEVELS     = 5,
  parameter int unsigned SECS_PER_LEVEL = 10,
  parameter int unsigned LVL_W          = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             run_i,
  input  logic             tick_i,
  output logic [LVL_W-1:0] level_o
);
  localparam int unsigned SEC_W = $clog2(SECS_PER_LEVEL + 1);
  localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(SECS_PER_LEVEL - 1);
  localparam logic [LVL_W-1:0] LVL_TOP  = LVL_W'(NUM_LEVELS - 1);

  logic [SEC_W-1:0] sec_q;
  logic [LVL_W-1:0] level_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q   <= '0;
      level_q <= '0;
    end else if (clear_i) begin
      sec_q   <= '0;
      level_q <= '0;
    end else if (run_i && tick_i) begin
      if (sec_q == SEC_LAST) begin
        sec_q <= '0;
        if (level_q != LVL_TOP) level_q <= level_q + 1'b1;
      end else begin
        sec_q <= sec_q + 1'b1;
      end
    end
  end

  assign level_o = level_q;
endmodule

// File: rtl/pong_step_gen.sv
module pong_step_gen #(
  parameter int unsigned NUM_LEVELS  = 5,
  parameter int unsigned LVL_W       = 3,
  parameter int unsigned BASE_PERIOD = 5_000_000,
  parameter int unsigned PERIOD_DEC  = 1_000_000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [LVL_W-1:0] level_i,
  output logic             step_o
);
  localparam int unsigned CNT_W = $clog2(BASE_PERIOD + 1);

  logic [CNT_W-1:0] wrap_tab [NUM_LEVELS];
  logic [CNT_W-1:0] wrap_sel;
  logic [CNT_W-1:0] cnt_q;
  logic             step_q;

  for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_wrap
    assign wrap_tab[g] = CNT_W'(BASE_PERIOD - g * PERIOD_DEC - 1);
  end

  always_comb begin
    wrap_sel = wrap_tab[NUM_LEVELS-1];
    for (int i = 0; i < NUM_LEVELS; i++) begin
      if (level_i == LVL_W'(i)) wrap_sel = wrap_tab[i];
    end
  end

  // >= lets a level rise mid-period shorten the current period without a stall
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      step_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q  <= '0;
      step_q <= 1'b0;
    end else if (cnt_q >= wrap_sel) begin
      cnt_q  <= '0;
      step_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      step_q <= 1'b0;
    end
  end

  assign step_o = step_q;
endmodule

// File: rtl/pong_flow_ctrl.sv
module pong_flow_ctrl
  import pong_ctrl_pkg::*;
#(
  parameter int unsigned NUM_LEVELS     = 5,
  parameter int unsigned SECS_PER_LEVEL = 10,
  parameter int unsigned BASE_PERIOD    = 5_000_000,
  parameter int unsigned PERIOD_DEC     = 1_000_000,
  parameter int unsigned SYNC_STAGES    = 2,
  localparam int unsigned LVL_W         = $clog2(NUM_LEVELS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reset_btn_i,
  input  logic             start_btn_i,
  input  logic             miss_i,
  input  logic             sec_tick_i,
  output logic             playing_o,
  output logic             over_o,
  output logic [LVL_W-1:0] speed_sel_o,
  output logic             step_o
);
  game_st_e   state_q, state_d;
  logic       rst_press, start_press;
  logic       lvl_clear, lvl_run, in_play;

  pong_btn_edge #(.STAGES(SYNC_STAGES)) u_rst_btn (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .btn_i  (reset_btn_i),
    .press_o(rst_press)
  );

  pong_btn_edge #(.STAGES(SYNC_STAGES)) u_start_btn (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .btn_i  (start_btn_i),
    .press_o(start_press)
  );

  always_comb begin
    state_d = state_q;
    if (rst_press) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_press) state_d = ST_PLAY;
        ST_PLAY: if (miss_i)      state_d = ST_OVER;
        ST_OVER: state_d = ST_OVER;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign in_play   = (state_q == ST_PLAY);
  assign lvl_clear = rst_press | ((state_q == ST_IDLE) & start_press);
  assign lvl_run   = in_play & ~miss_i;

  pong_level_ctr #(
    .NUM_LEVELS    (NUM_LEVELS),
    .SECS_PER_LEVEL(SECS_PER_LEVEL),
    .LVL_W         (LVL_W)
  ) u_level (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(lvl_clear),
    .run_i  (lvl_run),
    .tick_i (sec_tick_i),
    .level_o(speed_sel_o)
  );

  pong_step_gen #(
    .NUM_LEVELS (NUM_LEVELS),
    .LVL_W      (LVL_W),
    .BASE_PERIOD(BASE_PERIOD),
    .PERIOD_DEC (PERIOD_DEC)
  ) u_step (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (in_play),
    .level_i(speed_sel_o),
    .step_o (step_o)
  );

  assign playing_o = in_play;
  assign over_o    = (state_q == ST_OVER);
endmodule

// File: rtl/pong_flow_ctrl_chk.sv
module pong_flow_ctrl_chk #(
  parameter int unsigned NUM_LEVELS = 5,
  parameter int unsigned LVL_W      = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             playing_o,
  input logic             over_o,
  input logic [LVL_W-1:0] speed_sel_o,
  input logic             step_o
);
  localparam logic [LVL_W-1:0] TOP = LVL_W'(NUM_LEVELS - 1);

  AST_STATE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(playing_o && over_o)); // R3

  AST_SPEED_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    speed_sel_o <= TOP); // R5

  AST_LEVEL_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (speed_sel_o != $past(speed_sel_o)) |->
      (speed_sel_o == LVL_W'($past(speed_sel_o) + 1'b1)) || (speed_sel_o == '0)); // R4

  AST_SATURATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(speed_sel_o) == TOP && playing_o && $past(playing_o)) |-> speed_sel_o == TOP); // R5

  AST_STEP_IN_PLAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |-> $past(playing_o)); // R6

  AST_OVER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (over_o && $past(over_o)) |-> $stable(speed_sel_o)); // R7
endmodule

bind pong_flow_ctrl pong_flow_ctrl_chk #(
  .NUM_LEVELS(NUM_LEVELS),
  .LVL_W     (LVL_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .playing_o  (playing_o),
  .over_o     (over_o),
  .speed_sel_o(speed_sel_o),
  .step_o     (step_o)
);

// File: tb/pong_flow_ctrl_tb.sv
`timescale 1ns/1ps
module pong_flow_ctrl_tb;
  localparam int NL   = 5;
  localparam int SECS = 3;
  localparam int BASE = 12;
  localparam int DEC  = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rbtn = 1'b0, sbtn = 1'b0, miss = 1'b0, tick = 1'b0;
  logic       playing, over, step;
  logic [2:0] speed;
  int         total = 0, bad = 0, cyc = 0, ticks = 0;

  always #5 clk = ~clk;

  pong_flow_ctrl #(
    .NUM_LEVELS(NL), .SECS_PER_LEVEL(SECS), .BASE_PERIOD(BASE), .PERIOD_DEC(DEC)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reset_btn_i(rbtn), .start_btn_i(sbtn),
    .miss_i(miss), .sec_tick_i(tick), .playing_o(playing), .over_o(over),
    .speed_sel_o(speed), .step_o(step)
  );

  function automatic int exp_lvl(int n);
    return (n / SECS > NL - 1) ? NL - 1 : n / SECS;
  endfunction

  function automatic int exp_period(int l);
    return BASE - l * DEC;
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d @%0t", req, act, exp, $time);
    end
  endtask

  task automatic press_start(int hold);
    @(negedge clk) sbtn = 1'b1;
    repeat (hold) @(negedge clk);
    sbtn = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic press_reset(int hold);
    @(negedge clk) rbtn = 1'b1;
    repeat (hold) @(negedge clk);
    rbtn = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic send_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic measure(output int per);
    int guard = 0;
    per = 0;
    while (!step && guard < 200) begin @(negedge clk); guard++; end
    do begin @(negedge clk); per++; end while (!step && per < 200);
  endtask

  task automatic count_steps(int n, output int cnt);
    cnt = 0;
    repeat (n) begin @(negedge clk); if (step) cnt++; end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int per, n;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 playing", playing, 0);
    chk("R1 over", over, 0);
    chk("R1 speed", speed, 0);
    count_steps(20, n);
    chk("R6 no step in idle", n, 0);
    // R11 ticks in idle ignored
    repeat (4) send_tick();
    chk("R11 idle ticks", speed, 0);
    // R2 start
    press_start(2);
    chk("R2 playing", playing, 1);
    chk("R2 over", over, 0);
    chk("R2 speed", speed, 0);
    measure(per);
    chk("R6 period lvl0", per, exp_period(0));
    // R4/R5 random tick gaps against the model
    ticks = 0;
    for (int i = 0; i < 20; i++) begin
      repeat ($urandom_range(0, 6)) @(negedge clk);
      send_tick();
      ticks++;
      chk("R4 level after tick", speed, exp_lvl(ticks));
      if (ticks == 2 * SECS) begin
        measure(per);
        chk("R6 period lvl2", per, exp_period(2));
      end
    end
    chk("R5 saturated", speed, NL - 1);
    measure(per);
    chk("R6 period lvl4", per, exp_period(4));
    // R11/R3 miss with tick in same cycle; ticks=20 leaves 2 toward the next rise
    @(negedge clk) begin miss = 1'b1; tick = 1'b1; end
    @(negedge clk) begin miss = 1'b0; tick = 1'b0; end
    chk("R3 over", over, 1);
    chk("R3 playing", playing, 0);
    chk("R11 miss beats tick", speed, NL - 1);
    count_steps(30, n);
    chk("R6 no step in over", n, 0);
    // R7 start and ticks ignored in game-over
    press_start(3);
    repeat (2) send_tick();
    chk("R7 still over", over, 1);
    chk("R7 not playing", playing, 0);
    chk("R7 speed held", speed, NL - 1);
    // R8 reset button
    press_reset(2);
    chk("R8 over", over, 0);
    chk("R8 playing", playing, 0);
    chk("R8 speed", speed, 0);
    // R10 a new game needs a full tick window
    press_start(2);
    chk("R10 playing", playing, 1);
    repeat (SECS - 1) send_tick();
    chk("R10 no early rise", speed, 0);
    send_tick();
    chk("R10 rise after full window", speed, 1);
    measure(per);
    chk("R6 period lvl1", per, exp_period(1));
    // R8 reset from play, R9 held reset acts once
    @(negedge clk) rbtn = 1'b1;
    repeat (8) @(negedge clk);
    chk("R8 reset from play", playing, 0);
    chk("R8 speed cleared", speed, 0);
    press_start(2);
    chk("R9 start under held reset", playing, 1);
    repeat (20) @(negedge clk);
    chk("R9 held reset no retrigger", playing, 1);
    rbtn = 1'b0;
    // R9 held start acts once: miss, keep start held, stay over
    @(negedge clk) sbtn = 1'b1;
    @(negedge clk) miss = 1'b1;
    @(negedge clk) miss = 1'b0;
    repeat (10) @(negedge clk);
    chk("R9 held start in over", over, 1);
    sbtn = 1'b0;
    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule